// File: doc/BRIEF.md
# Digital Potentiometer Register Bank and Non-Volatile Write Sequencer

This block sits behind a serial slave interface and holds the state of four 8-bit wiper channels. A single register port, a write strobe with a 5-bit address and a byte of data plus a combinational read path, reaches three kinds of storage. The first is four volatile wiper registers that drive the wiper codes. The second is four non-volatile initial-value bytes and eleven non-volatile general-purpose bytes. The third is one control register. The wiper and initial-value registers of a channel share one address, and a control bit selects which of the two an access reaches.

A write into the non-volatile space is held as pending until the serial interface reports the end of the transfer. A self-timed cycle then runs with a busy flag set, and at its end the byte is committed to a behavioural storage array. While that cycle runs, writes to the wipers and to the control register are locked out. At power-up the wipers sit at midscale. Once the supply is reported good and a recall delay has passed, every wiper is loaded from its stored initial value, and the register port opens.

Top module: `potbank_top`

## Requirements
- R1: From reset until `access_ready` rises, every wiper code is 80h. Writes are ignored and `reg_rdata` reads 00h. `access_ready` stays low until `supply_ok` has been high for `RECALL_CYCLES` cycles.
- R2: After the recall, each wiper channel holds its stored initial value and `access_ready` stays high. Stored bytes survive a later reset.
- R3: The control register at address 10h reads as {SEL_VOLATILE bit 7, RUN bit 6, BUSY bit 5, bits 4:0 = 0}. After reset it reads 40h.
- R4: `pot_shutdown` is 1 exactly when the RUN bit (bit 6 of the control register) is 0.
- R5: With SEL_VOLATILE = 1, addresses 0 to 3 read and write the wiper register of channel `addr`. A write shows on `wiper_codes` after one clock and leaves the stored bytes unchanged.
- R6: With SEL_VOLATILE = 0, addresses 0 to 3 reach the stored initial values. A write copies the byte into the matching wiper register after one clock, and the byte is committed to storage when the write cycle ends.
- R7: A pulse on `bus_stop` with a write pending sets BUSY for `NV_WRITE_CYCLES` clocks. Reads during that time return the old stored byte. The new byte is readable once BUSY clears.
- R8: While BUSY is 1, writes to the wiper registers and the control register are ignored, and new non-volatile write requests are dropped.
- R9: Addresses 04h to 0Eh are general-purpose stored bytes. They are written through the same timed cycle and read back.
- R10: Writes to address 0Fh and to addresses above 10h have no effect, and reads from them return 00h.
- R11: `wiper_codes[8*i+7:8*i]` is the code of channel i. Code 00h is nearest the low terminal and FFh nearest the high terminal.
- R12: A `bus_stop` pulse with no pending write does not start a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| supply_ok | input | 1 | Supply has reached the level for a reliable recall |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| bus_stop | input | 1 | One-cycle pulse at the end of a serial transfer |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| wiper_codes | output | 32 | Four packed wiper codes, channel 0 in the low byte |
| pot_shutdown | output | 1 | High while the potentiometers are in shutdown |
| access_ready | output | 1 | High once the power-up recall has completed |

## Verification
Register writes take effect at the clock edge that samples `reg_wr`. The wiper outputs and read data are therefore compared half a cycle later, and reads, being combinational, are compared a quarter cycle after the edge that follows the address change. BUSY rises at the edge that samples `bus_stop` and falls `NV_WRITE_CYCLES` edges later, together with the commit. The bench reads during that window for old values and after `NV_WRITE_CYCLES + 2` cycles for new ones. `access_ready` rises `RECALL_CYCLES + 2` edges after `supply_ok`. The bench checks it low at half that delay and high with margin past it.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
  localparam int CHANNELS  = 4;
  localparam int NV_REGS   = 15;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int NV_AW     = $clog2(NV_REGS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h10;
  localparam logic [ADDR_W-1:0] GP_LAST   = 5'h0E;
  localparam logic [DATA_W-1:0] MIDSCALE  = 8'h80;

  typedef enum logic [1:0] {K_CHAN, K_GP, K_CTRL, K_NONE} acc_kind_t;

  // Classify an address into the region it reaches.
  function automatic acc_kind_t classify(input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(CHANNELS))   return K_CHAN;
    else if (a <= GP_LAST)       return K_GP;
    else if (a == CTRL_ADDR)     return K_CTRL;
    else                         return K_NONE;
  endfunction

  // Pack the control register from its fields.
  function automatic logic [DATA_W-1:0] ctrl_byte(input logic sel_vol, input logic run,
                                                  input logic busy);
    return {sel_vol, run, busy, 5'b00000};
  endfunction
endpackage

// File: rtl/pb_nv_array.sv
module pb_nv_array
  import potbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] NV_INIT = 8'h00
) (
  input  logic                      clk,
  input  logic                      we_i,
  input  logic [NV_AW-1:0]          waddr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [NV_REGS*DATA_W-1:0] contents_o
);
  // Behavioural storage: not cleared by reset, so contents survive it.
  for (genvar g = 0; g < NV_REGS; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q = NV_INIT;
    always_ff @(posedge clk) begin
      if (we_i && waddr_i == NV_AW'(g)) cell_q <= wdata_i;
    end
    assign contents_o[g*DATA_W +: DATA_W] = cell_q;
  end
endmodule

// File: rtl/pb_nv_sequencer.sv
module pb_nv_sequencer
  import potbank_pkg::*;
#(
  parameter int NV_WRITE_CYCLES = 40,
  localparam int CNT_W = $clog2(NV_WRITE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [NV_AW-1:0]  req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [NV_AW-1:0]  commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o
);
  logic              pend_q, busy_q;
  logic [NV_AW-1:0]  addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              start_w;

  assign start_w  = !busy_q && stop_i && pend_q;
  assign commit_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_w) begin
      busy_q <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= CNT_W'(NV_WRITE_CYCLES - 1);
    end else if (req_i) begin
      pend_q <= 1'b1;
      addr_q <= req_addr_i;
      data_q <= req_data_i;
    end
  end

  assign busy_o        = busy_q;
  assign commit_addr_o = addr_q;
  assign commit_data_o = data_q;

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !commit_o) |=> busy_q);
  // R7
  commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_q);
  // R12
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && stop_i && !pend_q) |=> !busy_q);
endmodule

// File: rtl/pb_powerup.sv
module pb_powerup #(
  parameter int RECALL_CYCLES = 20,
  localparam int CNT_W = $clog2(RECALL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  output logic load_o,
  output logic ready_o
);
  typedef enum logic [1:0] {PU_PRESET, PU_WAIT, PU_LOAD, PU_READY} pu_state_t;
  pu_state_t        st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PU_PRESET;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PU_PRESET: if (supply_ok_i) begin st_q <= PU_WAIT; cnt_q <= '0; end
        PU_WAIT:   if (cnt_q == CNT_W'(RECALL_CYCLES - 1)) st_q <= PU_LOAD;
                   else cnt_q <= cnt_q + 1'b1;
        PU_LOAD:   st_q <= PU_READY;
        default:   st_q <= PU_READY;
      endcase
    end
  end

  assign load_o  = (st_q == PU_LOAD);
  assign ready_o = (st_q == PU_READY);

  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
  // R1
  load_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(load_o));
endmodule

// File: rtl/potbank_top.sv
module potbank_top
  import potbank_pkg::*;
#(
  parameter int NV_WRITE_CYCLES = 40,
  parameter int RECALL_CYCLES   = 20,
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        supply_ok,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        bus_stop,
  output logic [7:0]  reg_rdata,
  output logic [31:0] wiper_codes,
  output logic        pot_shutdown,
  output logic        access_ready
);
  logic [NV_REGS*DATA_W-1:0] nv_flat;
  logic              load_w, wip_w, commit_w;
  logic [NV_AW-1:0]  commit_addr_w;
  logic [DATA_W-1:0] commit_data_w;
  logic              sel_vol_q, run_q;
  logic [DATA_W-1:0] wiper_q [CHANNELS];

  acc_kind_t kind_w;
  logic      wr_ok_w, wr_wiper_w, wr_ctrl_w, nv_req_w, mirror_w;

  assign kind_w     = classify(reg_addr);
  assign wr_ok_w    = reg_wr && access_ready && !wip_w;
  assign wr_wiper_w = wr_ok_w && kind_w == K_CHAN && sel_vol_q;
  assign wr_ctrl_w  = wr_ok_w && kind_w == K_CTRL;
  assign nv_req_w   = wr_ok_w && ((kind_w == K_CHAN && !sel_vol_q) || kind_w == K_GP);
  assign mirror_w   = nv_req_w && kind_w == K_CHAN;

  pb_powerup #(.RECALL_CYCLES(RECALL_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok),
    .load_o(load_w), .ready_o(access_ready));

  pb_nv_sequencer #(.NV_WRITE_CYCLES(NV_WRITE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(nv_req_w),
    .req_addr_i(reg_addr[NV_AW-1:0]), .req_data_i(reg_wdata), .stop_i(bus_stop),
    .busy_o(wip_w), .commit_o(commit_w),
    .commit_addr_o(commit_addr_w), .commit_data_o(commit_data_w));

  pb_nv_array #(.NV_INIT(NV_INIT)) u_nv (
    .clk(clk), .we_i(commit_w), .waddr_i(commit_addr_w), .wdata_i(commit_data_w),
    .contents_o(nv_flat));

  // Control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vol_q <= 1'b0;
      run_q     <= 1'b1;
    end else if (wr_ctrl_w) begin
      sel_vol_q <= reg_wdata[7];
      run_q     <= reg_wdata[6];
    end
  end

  // Wiper registers, one per channel
  for (genvar c = 0; c < CHANNELS; c++) begin : g_wiper
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    wiper_q[c] <= MIDSCALE;
      else if (load_w)               wiper_q[c] <= nv_flat[c*DATA_W +: DATA_W];
      else if ((wr_wiper_w || mirror_w) && reg_addr[1:0] == 2'(c))
                                     wiper_q[c] <= reg_wdata;
    end
    assign wiper_codes[c*DATA_W +: DATA_W] = wiper_q[c];
  end

  // Read path
  always_comb begin
    reg_rdata = '0;
    if (access_ready) begin
      case (kind_w)
        K_CHAN:  reg_rdata = sel_vol_q ? wiper_q[reg_addr[1:0]]
                                       : nv_flat[reg_addr[NV_AW-1:0]*DATA_W +: DATA_W];
        K_GP:    reg_rdata = nv_flat[reg_addr[NV_AW-1:0]*DATA_W +: DATA_W];
        K_CTRL:  reg_rdata = ctrl_byte(sel_vol_q, run_q, wip_w);
        default: reg_rdata = '0;
      endcase
    end
  end

  assign pot_shutdown = !run_q;

  // R1
  preset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !access_ready |-> wiper_codes == {CHANNELS{MIDSCALE}});
  // R8
  ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_w && reg_wr && kind_w == K_CTRL) |=> $stable({sel_vol_q, run_q}));
  // R8
  wiper_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_w && access_ready && !commit_w) |=> $stable(wiper_codes));
  // R10
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_ready && reg_wr && kind_w == K_NONE) |=>
      ($stable(wiper_codes) && $stable({sel_vol_q, run_q})));
endmodule

// File: tb/test_potbank_top.sv
module test_potbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVW = 12;
  localparam int RCL = 8;

  logic clk = 0, rst_n = 0, supply_ok = 0, reg_wr = 0, bus_stop = 0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [31:0] wiper_codes;
  logic        pot_shutdown, access_ready;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [4:0] addr; logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  potbank_top #(.NV_WRITE_CYCLES(NVW), .RECALL_CYCLES(RCL), .NV_INIT(8'h00)) i_potbank_top (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .bus_stop(bus_stop),
    .reg_rdata(reg_rdata), .wiper_codes(wiper_codes),
    .pot_shutdown(pot_shutdown), .access_ready(access_ready));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: compare read data a quarter cycle after the edge following a push.
  always begin
    @(posedge clk);
    if (sb_q.size() > 0) begin
      rd_item_t it;
      #(CLK_PERIOD/4);
      it = sb_q.pop_front();
      check(it.tag, {24'h0, reg_rdata}, {24'h0, it.exp});
    end
  end

  task automatic rd_expect(input logic [4:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb_q.push_back('{addr: a, exp: e, tag: tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    bus_stop = 1;
    @(negedge clk);
    bus_stop = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1;
    cycles(2);
    // R1: preset state, port closed
    check("R1 wipers preset", wiper_codes, 32'h80808080);
    check("R1 not ready", {31'h0, access_ready}, 32'h0);
    wr(5'h10, 8'h00);
    rd_expect(5'h10, 8'h00, "R1 read closed");
    supply_ok = 1;
    cycles(RCL/2);
    check("R1 still not ready", {31'h0, access_ready}, 32'h0);
    check("R1 still preset", wiper_codes, 32'h80808080);
    cycles(RCL + 4);
    // R2: recall
    check("R2 ready", {31'h0, access_ready}, 32'h1);
    check("R2 recalled", wiper_codes, 32'h00000000);
    // R3: control reset value (early write ignored per R1)
    rd_expect(5'h10, 8'h40, "R3 ctrl reset");
    check("R4 running", {31'h0, pot_shutdown}, 32'h0);
    wr(5'h10, 8'h00);
    check("R4 shutdown", {31'h0, pot_shutdown}, 32'h1);
    rd_expect(5'h10, 8'h00, "R3 ctrl 00");
    wr(5'h10, 8'hC0);
    check("R4 run again", {31'h0, pot_shutdown}, 32'h0);
    rd_expect(5'h10, 8'hC0, "R3 ctrl C0");
    // R5 / R11: volatile wiper write
    wr(5'h02, 8'h5A);
    check("R5 R11 wiper2", wiper_codes, 32'h005A0000);
    rd_expect(5'h02, 8'h5A, "R5 read wiper2");
    wr(5'h10, 8'h40);
    rd_expect(5'h02, 8'h00, "R5 stored untouched");
    // R6: stored write mirrors
    wr(5'h01, 8'h3C);
    check("R6 mirror", wiper_codes, 32'h005A3C00);
    rd_expect(5'h01, 8'h00, "R6 not yet committed");
    stop_pulse();
    rd_expect(5'h10, 8'h60, "R7 busy set");
    rd_expect(5'h01, 8'h00, "R7 old value during busy");
    // R8: lockout
    wr(5'h10, 8'hC0);
    rd_expect(5'h10, 8'h60, "R8 ctrl locked");
    wr(5'h00, 8'h11);
    check("R8 wiper locked", wiper_codes, 32'h005A3C00);
    cycles(NVW + 2);
    rd_expect(5'h10, 8'h40, "R7 busy clear");
    rd_expect(5'h01, 8'h3C, "R6 R7 committed");
    rd_expect(5'h00, 8'h00, "R8 dropped request");
    // R12
    stop_pulse();
    rd_expect(5'h10, 8'h40, "R12 no cycle");
    // R9
    wr(5'h07, 8'hA5);
    stop_pulse();
    rd_expect(5'h07, 8'h00, "R9 old during busy");
    cycles(NVW + 2);
    rd_expect(5'h07, 8'hA5, "R9 gp committed");
    wr(5'h0E, 8'h3E);
    stop_pulse();
    cycles(NVW + 2);
    rd_expect(5'h0E, 8'h3E, "R9 last gp");
    // R10
    wr(5'h0F, 8'h77);
    wr(5'h13, 8'h55);
    rd_expect(5'h0F, 8'h00, "R10 read F");
    rd_expect(5'h13, 8'h00, "R10 read 13");
    rd_expect(5'h10, 8'h40, "R10 ctrl intact");
    check("R10 wipers intact", wiper_codes, 32'h005A3C00);
    stop_pulse();
    rd_expect(5'h10, 8'h40, "R10 R12 no cycle");
    // R2: re-power keeps stored bytes
    @(negedge clk); rst_n = 0;
    cycles(2);
    rst_n = 1;
    cycles(1);
    check("R1 preset again", wiper_codes, 32'h80808080);
    cycles(RCL + 4);
    check("R2 ready again", {31'h0, access_ready}, 32'h1);
    check("R2 recall kept", wiper_codes, 32'h00003C00);
    rd_expect(5'h07, 8'hA5, "R2 gp kept");
    rd_expect(5'h10, 8'h40, "R3 ctrl after reset");
    cycles(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule